// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 36-bit words between two clock domains. Words enter on the write clock and leave on the read clock. The two clocks may be unrelated, or they may be one and the same clock. A port moves a word on a rising edge of its clock only when its select input is low and its enable input is high. The write and read pointers cross between the domains as Gray code through two-flop synchronisers. Because of this, the flags on each side are conservative by the latency of the synchroniser.

Each side has two flags. The write side has a capacity flag and an active-low nearly-full flag. The read side has a data flag and an active-low nearly-empty flag. Both thresholds are live inputs, supplied by a separate offset register block. A timing-mode input is captured on the first clock edge after reset, and the pin is ignored from then on. The mode sets how the block behaves:

- **Standard mode:** a read request loads the next word into the output register. The capacity flag means "full" and the data flag means "empty".
- **Look-ahead mode:** the oldest word is placed on the output without any request, and each read replaces it with the next one. The capacity flag means "room to write" and the data flag means "output valid".

Top module: `dcfifo_flagged`

## Requirements
- R1: A write happens only on a rising wclk edge with w_cs_n=0 and w_en=1. A read happens only on a rising rclk edge with r_cs_n=0 and r_en=1. Any other combination leaves the contents and the flags unchanged.
- R2: In standard mode (fwft_sel=0 at capture), r_flag is 1 when nothing is stored. A read loads the oldest stored word into r_data, so it is visible after that rclk edge. Words come out in the order they were written.
- R3: In standard mode, w_flag is 1 when DEPTH words are stored. A write attempted while w_flag is 1 is dropped.
- R4: A read attempted while the FIFO is empty is dropped and does not move the read pointer.
- R5: In look-ahead mode (fwft_sel=1 at capture), the oldest word appears on r_data with r_flag=1 and no read request. r_data holds while no read is made. Each read replaces r_data with the next word, or drops r_flag to 0 if no word is left.
- R6: In look-ahead mode, w_flag is 1 while there is room to write and 0 once the FIFO is full.
- R7: fwft_sel is captured on the first clock edge after reset is released. Later changes to the pin have no effect until the next reset.
- R8: ae_n is 0 when the stored-word count, as seen in the read domain, is less than or equal to ae_thr. Otherwise ae_n is 1.
- R9: af_n is 0 when the free-location count, as seen in the write domain, is less than or equal to af_thr. Otherwise af_n is 1.
- R10: A write becomes visible on the read-side flags two rclk edges after the write edge. With a shared clock, r_flag first falls after the second edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| w_cs_n | input | 1 | Write select, active low |
| w_en | input | 1 | Write enable, active high |
| w_data | input | DW | Write data |
| w_flag | output | 1 | Full (standard) or input ready (look-ahead) |
| af_n | output | 1 | Nearly full, active low |
| af_thr | input | AW+1 | Free-location threshold for af_n |
| rclk | input | 1 | Read clock |
| r_cs_n | input | 1 | Read select, active low |
| r_en | input | 1 | Read enable, active high |
| r_data | output | DW | Read data register |
| r_flag | output | 1 | Empty (standard) or output valid (look-ahead) |
| ae_n | output | 1 | Nearly empty, active low |
| ae_thr | input | AW+1 | Stored-word threshold for ae_n |
| fwft_sel | input | 1 | Timing mode, captured after reset |

## Verification
In look-ahead mode, two things can happen on the same read edge. The consumer takes the word held in the output register, and a fresh word is fetched from memory into that register. The bench sets this up by queueing several words and then issuing reads back to back. It then checks that each read leaves the next word on r_data, and that r_flag never drops in between. A second overlap is a dropped write at full followed by a drain. Reading all the words back shows that the extra write neither overwrote a word nor added one.

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          w_cs_n,
  input  logic          w_en,
  input  logic [DW-1:0] w_data,
  output logic          w_flag,
  output logic          af_n,
  input  logic [AW:0]   af_thr,
  input  logic          rclk,
  input  logic          r_cs_n,
  input  logic          r_en,
  output logic [DW-1:0] r_data,
  output logic          r_flag,
  output logic          ae_n,
  input  logic [AW:0]   ae_thr,
  input  logic          fwft_sel
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic          mode_w, armed_w;
  logic [PW-1:0] wused, wfree;
  logic          wfull, wr_go;

  assign wused = wbin - g2b(rg_s2);
  assign wfree = PW'(DEPTH) - wused;
  assign wfull = (wused == PW'(DEPTH));
  assign wr_go = !w_cs_n && w_en && !wfull;
  assign w_flag = mode_w ? !wfull : wfull;
  assign af_n = !(wfree <= af_thr);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      mode_w <= 1'b0;
      armed_w <= 1'b0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (!armed_w) begin
        armed_w <= 1'b1;
        mode_w <= fwft_sel;
      end
      if (wr_go) begin
        wbin <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= w_data;
  end

  // read domain
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          mode_r, armed_r, ovalid;
  logic [PW-1:0] rused;
  logic          mem_empty, r_req, fetch, pop;

  assign mem_empty = (rbin == g2b(wg_s2));
  assign r_req = !r_cs_n && r_en;
  assign fetch = mode_r && !mem_empty && (!ovalid || r_req);
  assign pop = fetch || (!mode_r && r_req && !mem_empty);
  assign rused = g2b(wg_s2) - rbin + PW'(ovalid);
  assign r_flag = mode_r ? ovalid : mem_empty;
  assign ae_n = !(rused <= ae_thr);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      mode_r <= 1'b0;
      armed_r <= 1'b0;
      ovalid <= 1'b0;
      r_data <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (!armed_r) begin
        armed_r <= 1'b1;
        mode_r <= fwft_sel;
      end
      if (pop) begin
        rbin <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        r_data <= mem[rbin[AW-1:0]];
      end
      if (fetch) ovalid <= 1'b1;
      else if (r_req && ovalid) ovalid <= 1'b0;
    end
  end
endmodule

// File: rtl/dcfifo_flagged_chk.sv
module dcfifo_flagged_chk #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input logic          rst_n,
  input logic          wclk,
  input logic          rclk,
  input logic          w_cs_n,
  input logic          w_en,
  input logic          r_cs_n,
  input logic          r_en,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rbin,
  input logic          wfull,
  input logic          mem_empty,
  input logic          mode_w,
  input logic          armed_w,
  input logic          mode_r,
  input logic          ovalid,
  input logic [DW-1:0] r_data
);
  AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R10
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    (wfull && !w_cs_n && w_en) |=> $stable(wbin)); // R3
  AST_WR_GATED: assert property (@(posedge wclk) disable iff (!rst_n)
    (w_cs_n || !w_en) |=> $stable(wbin)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (mem_empty && !mode_r) |=> $stable(rbin)); // R4
  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    armed_w |=> $stable(mode_w)); // R7
  AST_HEAD_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_r && ovalid && (r_cs_n || !r_en)) |=> $stable(r_data)); // R5
endmodule

bind dcfifo_flagged dcfifo_flagged_chk #(.DW(DW), .AW(AW)) chk_i (
  .rst_n(rst_n), .wclk(wclk), .rclk(rclk),
  .w_cs_n(w_cs_n), .w_en(w_en), .r_cs_n(r_cs_n), .r_en(r_en),
  .wbin(wbin), .wgray(wgray), .rbin(rbin),
  .wfull(wfull), .mem_empty(mem_empty),
  .mode_w(mode_w), .armed_w(armed_w), .mode_r(mode_r),
  .ovalid(ovalid), .r_data(r_data)
);

// File: tb/dcfifo_flagged_tb_top.sv
module dcfifo_flagged_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int NVEC = 7;
  // {count[4:0], ae_thr[4:0], af_thr[4:0], exp_ae_n, exp_af_n}
  localparam logic [16:0] VEC [NVEC] = '{
    {5'd0,  5'd0,  5'd0,  1'b0, 1'b1},
    {5'd1,  5'd0,  5'd2,  1'b1, 1'b1},
    {5'd3,  5'd3,  5'd4,  1'b0, 1'b1},
    {5'd4,  5'd3,  5'd12, 1'b1, 1'b0},
    {5'd14, 5'd8,  5'd1,  1'b1, 1'b1},
    {5'd15, 5'd15, 5'd1,  1'b0, 1'b0},
    {5'd16, 5'd2,  5'd0,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w_cs_n = 1'b1, w_en = 1'b0, r_cs_n = 1'b1, r_en = 1'b0, fwft_sel = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic [AW:0] af_thr = '0, ae_thr = '0;
  logic [DW-1:0] r_data;
  logic w_flag, af_n, r_flag, ae_n;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcfifo_flagged #(.DW(DW), .AW(AW)) dut_i (
    .rst_n(rst_n), .wclk(clk), .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data),
    .w_flag(w_flag), .af_n(af_n), .af_thr(af_thr),
    .rclk(clk), .r_cs_n(r_cs_n), .r_en(r_en), .r_data(r_data),
    .r_flag(r_flag), .ae_n(ae_n), .ae_thr(ae_thr), .fwft_sel(fwft_sel)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    fwft_sel = mode;
    w_cs_n = 1'b1; w_en = 1'b0; r_cs_n = 1'b1; r_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic cs_n = 1'b0, input logic en = 1'b1);
    w_cs_n = cs_n; w_en = en; w_data = d;
    @(negedge clk);
    w_cs_n = 1'b1; w_en = 1'b0;
  endtask

  task automatic rd(input logic cs_n = 1'b0, input logic en = 1'b1);
    r_cs_n = cs_n; r_en = en;
    @(negedge clk);
    r_cs_n = 1'b1; r_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // reset state, standard mode
    ae_thr = 5'd0; af_thr = 5'd2;
    do_reset(1'b0);
    chk("R3 reset w_flag", w_flag, 0);
    chk("R2 reset r_flag", r_flag, 1);
    chk("R8 reset ae_n", ae_n, 0);
    chk("R9 reset af_n", af_n, 1);

    // threshold table
    for (int v = 0; v < NVEC; v++) begin
      do_reset(1'b0);
      ae_thr = VEC[v][11:7];
      af_thr = VEC[v][6:2];
      for (int k = 0; k < int'(VEC[v][16:12]); k++) wr(DW'(k));
      idle(4);
      chk("R8 ae_n table", ae_n, VEC[v][1]);
      chk("R9 af_n table", af_n, VEC[v][0]);
    end

    // R1: gated writes and reads
    do_reset(1'b0);
    wr(36'h111, 1'b1, 1'b1);
    wr(36'h222, 1'b0, 1'b0);
    idle(4);
    chk("R1 gated write", r_flag, 1);
    wr(36'h333);
    idle(4);
    rd(1'b1, 1'b1);
    rd(1'b0, 1'b0);
    idle(2);
    chk("R1 gated read", r_flag, 0);
    rd();
    chk("R1 enabled read data", r_data, 36'h333);

    // R10: synchroniser latency
    do_reset(1'b0);
    wr(36'h5);
    chk("R10 empty after edge k", r_flag, 1);
    idle(1);
    chk("R10 empty after edge k+1", r_flag, 1);
    idle(1);
    chk("R10 not empty after edge k+2", r_flag, 0);

    // R2/R3/R4: fill, overflow attempt, drain, underflow attempt
    do_reset(1'b0);
    for (int k = 0; k < 16; k++) wr(36'hA00 + DW'(k));
    idle(4);
    chk("R3 full flag", w_flag, 1);
    wr(36'hDEAD);
    idle(4);
    for (int k = 0; k < 16; k++) begin
      rd();
      chk("R2 order", r_data, 36'hA00 + DW'(k));
    end
    idle(4);
    chk("R2 empty after drain", r_flag, 1);
    chk("R3 full cleared", w_flag, 0);
    rd();
    idle(2);
    wr(36'h55);
    idle(4);
    chk("R4 not empty after write", r_flag, 0);
    rd();
    chk("R4 read pointer held", r_data, 36'h55);

    // R7: pin change after capture ignored
    do_reset(1'b0);
    fwft_sel = 1'b1;
    wr(36'h77);
    idle(4);
    chk("R7 standard kept", r_flag, 0);
    chk("R7 no fall-through", r_data, 0);
    fwft_sel = 1'b0;

    // R5: look-ahead output
    do_reset(1'b1);
    chk("R5 reset r_flag", r_flag, 0);
    chk("R6 reset w_flag", w_flag, 1);
    wr(36'hA);
    idle(4);
    chk("R5 head valid", r_flag, 1);
    chk("R5 head data", r_data, 36'hA);
    wr(36'hB);
    wr(36'hC);
    idle(4);
    chk("R5 head held", r_data, 36'hA);
    rd();
    chk("R5 advance B", r_data, 36'hB);
    chk("R5 valid kept", r_flag, 1);
    rd();
    chk("R5 advance C", r_data, 36'hC);
    rd();
    chk("R5 drained", r_flag, 0);

    // R6: look-ahead fill
    do_reset(1'b1);
    for (int k = 0; k < 24; k++) begin
      if (w_flag) wr(DW'(k));
      else idle(1);
    end
    idle(6);
    chk("R6 no room", w_flag, 0);
    rd();
    idle(6);
    chk("R6 room again", w_flag, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule